// File: doc/BRIEF.md
# Mode-Selected Time Field Setter

This block keeps a 24-hour time of day and two further time values: an alarm setting and a countdown-timer preset. Each value is three fields of two packed BCD digits. The time of day advances by one second on every 1 Hz tick. Two mode switches pick the active context: normal run, clock adjust, alarm set or timer set.

In any of the three set contexts, a single key-driven state machine walks a selection pointer through hours, minutes and seconds. While a field is selected, active-low increment and decrement inputs change that field by one count per tick. The outputs are the three BCD fields of the context on display and a two-bit code for the display multiplexer.

All state changes happen on a clock edge that has the tick enable high. Display scanning, tone generation and switch debouncing are handled elsewhere.

Top module: `time_field_setter`

## Requirements
- R1: The switches `{set_sw_i, ds_sw_i}` select the context: 2'b11 normal run, 2'b00 clock adjust, 2'b01 alarm set, 2'b10 timer set. After the tick on which a new context is taken up, `disp_sel_o` equals that 2-bit code. The outputs show the alarm register for 01, the timer register for 10, and the clock register for 11 and 00.
- R2: In a set context, each falling edge of `key_ni`, sampled on ticks, moves the selection one step: idle, then hours, minutes, seconds, and back to hours. A key held low across several ticks advances the selection only once.
- R3: On the tick that enters a set context from any other context, the selection goes to idle. While the selection is idle, increment and decrement change nothing.
- R4: Outside clock adjust, the clock register advances by one second per tick. Seconds and minutes roll 59 to 00 with carry into the next field, and hours roll 23 to 00.
- R5: With `inc_ni` low, the selected field of the edited register rises by one per tick. Minutes and seconds wrap 59 to 00 and hours wrap 23 to 00, with no carry into another field.
- R6: With `dec_ni` low and `inc_ni` high, the selected field falls by one per tick. Minutes and seconds wrap 00 to 59 and hours wrap 00 to 23, with no borrow from another field.
- R7: While the clock-adjust context is active, the clock register does not advance on its own.
- R8: An active-low asynchronous reset clears all three registers to 00:00:00 and returns to normal run with `disp_sel_o` = 2'b11.
- R9: Each output field carries the tens digit in bits [7:4] and the units digit in bits [3:0]. Every digit stays within its legal range.
- R10: Nothing changes on a clock edge where `tick_i` is low, whatever the other inputs are.
- R11: If increment and decrement are both low on a tick, the increment is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 Hz enable |
| set_sw_i | input | 1 | Mode switch, upper bit of the context code |
| ds_sw_i | input | 1 | Mode switch, lower bit of the context code |
| key_ni | input | 1 | Field-select key, active low |
| inc_ni | input | 1 | Increment selected field, active low |
| dec_ni | input | 1 | Decrement selected field, active low |
| hour_o | output | 8 | BCD hours of the displayed register |
| min_o | output | 8 | BCD minutes of the displayed register |
| sec_o | output | 8 | BCD seconds of the displayed register |
| disp_sel_o | output | 2 | Display multiplexer code |

## Verification
A table of ticks drives the key state machine through all four contexts. One sequence holds the key low across ticks, which separates edge detection from level detection. Increment and decrement are applied at 00, 23 and 59, so a wrap can be told apart from a carry or borrow into the neighbouring field, and both strobes together expose the priority rule. Switching between alarm and timer after editing shows that each context keeps its own register and re-enters idle. Long free runs through 00:00:10, 00:01:00 and 01:00:00 test BCD digit rollover and the carry chain of the running clock.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int FIELD_W = 8;
  localparam int N_FIELDS = 3;  // 0 sec, 1 min, 2 hour
  localparam int N_BANKS = 3;   // 0 clock, 1 alarm, 2 timer

  typedef enum logic [1:0] {
    CTX_ADJ = 2'b00,
    CTX_ALM = 2'b01,
    CTX_TMR = 2'b10,
    CTX_RUN = 2'b11
  } ctx_e;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_HR   = 2'd1,
    SEL_MIN  = 2'd2,
    SEL_SEC  = 2'd3
  } sel_e;

  function automatic logic [FIELD_W-1:0] bcd_up(input logic [FIELD_W-1:0] v);
    if (v[3:0] == 4'd9) return {4'(v[7:4] + 4'd1), 4'd0};
    return {v[7:4], 4'(v[3:0] + 4'd1)};
  endfunction

  function automatic logic [FIELD_W-1:0] bcd_dn(input logic [FIELD_W-1:0] v);
    if (v[3:0] == 4'd0) return {4'(v[7:4] - 4'd1), 4'd9};
    return {v[7:4], 4'(v[3:0] - 4'd1)};
  endfunction
endpackage

// File: rtl/tfs_bcd_field.sv
module tfs_bcd_field
  import tfs_pkg::*;
#(
  parameter logic [FIELD_W-1:0] MAX_VAL = 8'h59
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               up_i,
  input  logic               dn_i,
  output logic [FIELD_W-1:0] val_o
);
  logic [FIELD_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (up_i) q_q <= (q_q == MAX_VAL) ? '0 : bcd_up(q_q);
    else if (dn_i) q_q <= (q_q == '0) ? MAX_VAL : bcd_dn(q_q);
  end

  assign val_o = q_q;

  a_r9_bcd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q[3:0] <= 4'd9) && (q_q <= MAX_VAL));
  a_r5_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && q_q == MAX_VAL) |=> (q_q == '0));
  a_r6_dn_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i && q_q == '0) |=> (q_q == MAX_VAL));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !dn_i) |=> $stable(q_q));
endmodule

// File: rtl/tfs_time_bank.sv
module tfs_time_bank
  import tfs_pkg::*;
#(
  parameter bit   AUTO_RUN = 1'b0,
  parameter ctx_e EDIT_CTX = CTX_ADJ
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  ctx_e               ctx_i,
  input  sel_e               field_i,
  input  logic               inc_i,
  input  logic               dec_i,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] sec_o
);
  logic                edit;
  logic                run;
  logic [N_FIELDS-1:0] carry;
  logic [N_FIELDS-1:0] up;
  logic [N_FIELDS-1:0] dn;
  logic [FIELD_W-1:0]  val [N_FIELDS];

  assign edit = (ctx_i == EDIT_CTX);

  generate
    if (AUTO_RUN) begin : g_auto
      assign run = !edit;
    end else begin : g_static
      assign run = 1'b0;
    end
  endgenerate

  assign carry[0] = 1'b1;
  assign carry[1] = (val[0] == 8'h59);
  assign carry[2] = carry[1] && (val[1] == 8'h59);

  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_field
    localparam sel_e FSEL = sel_e'(2'(3 - gi));
    localparam logic [FIELD_W-1:0] FMAX = (gi == N_FIELDS - 1) ? 8'h23 : 8'h59;
    logic hit;
    assign hit = edit && (field_i == FSEL);
    assign up[gi] = tick_i && ((run && carry[gi]) || (hit && inc_i));
    assign dn[gi] = tick_i && !run && hit && dec_i;

    tfs_bcd_field #(.MAX_VAL(FMAX)) u_field (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .up_i  (up[gi]),
      .dn_i  (dn[gi]),
      .val_o (val[gi])
    );
  end

  assign sec_o  = val[0];
  assign min_o  = val[1];
  assign hour_o = val[2];

  // R5: a manual edit never ripples into a neighbouring field
  a_r5_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !run && edit && field_i == SEL_SEC) |=> ($stable(min_o) && $stable(hour_o)));
endmodule

// File: rtl/tfs_set_fsm.sv
module tfs_set_fsm
  import tfs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic set_sw_i,
  input  logic ds_sw_i,
  input  logic key_ni,
  output ctx_e ctx_o,
  output sel_e field_o
);
  ctx_e mode;
  ctx_e ctx_q;
  sel_e sel_q;
  sel_e sel_nxt;
  logic key_q;
  logic press;

  assign mode  = ctx_e'({set_sw_i, ds_sw_i});
  assign press = key_q && !key_ni;

  always_comb begin
    unique case (sel_q)
      SEL_IDLE: sel_nxt = SEL_HR;
      SEL_HR:   sel_nxt = SEL_MIN;
      SEL_MIN:  sel_nxt = SEL_SEC;
      default:  sel_nxt = SEL_HR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q <= CTX_RUN;
      sel_q <= SEL_IDLE;
      key_q <= 1'b1;
    end else if (tick_i) begin
      key_q <= key_ni;
      if (mode != ctx_q) begin
        ctx_q <= mode;
        sel_q <= SEL_IDLE;
      end else if (ctx_q == CTX_RUN) begin
        sel_q <= SEL_IDLE;
      end else if (press) begin
        sel_q <= sel_nxt;
      end
    end
  end

  assign ctx_o   = ctx_q;
  assign field_o = sel_q;

  a_r3_enter_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode != ctx_q) |=> (sel_q == SEL_IDLE));
  a_r1_run_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_q == CTX_RUN && $stable(ctx_q)) |-> (sel_q == SEL_IDLE));
  a_r10_fsm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(sel_q) && $stable(ctx_q)));
  a_r2_held_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !key_q && mode == ctx_q) |=> $stable(sel_q));
endmodule

// File: rtl/time_field_setter.sv
module time_field_setter
  import tfs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               set_sw_i,
  input  logic               ds_sw_i,
  input  logic               key_ni,
  input  logic               inc_ni,
  input  logic               dec_ni,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] sec_o,
  output logic [1:0]         disp_sel_o
);
  ctx_e               ctx;
  sel_e               field;
  logic [FIELD_W-1:0] bh [N_BANKS];
  logic [FIELD_W-1:0] bm [N_BANKS];
  logic [FIELD_W-1:0] bs [N_BANKS];

  tfs_set_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .set_sw_i(set_sw_i),
    .ds_sw_i (ds_sw_i),
    .key_ni  (key_ni),
    .ctx_o   (ctx),
    .field_o (field)
  );

  // bank 0 = clock (edited in ADJ), 1 = alarm, 2 = timer
  for (genvar bi = 0; bi < N_BANKS; bi++) begin : g_bank
    tfs_time_bank #(
      .AUTO_RUN(bi == 0),
      .EDIT_CTX(ctx_e'(2'(bi)))
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .ctx_i  (ctx),
      .field_i(field),
      .inc_i  (!inc_ni),
      .dec_i  (!dec_ni),
      .hour_o (bh[bi]),
      .min_o  (bm[bi]),
      .sec_o  (bs[bi])
    );
  end

  always_comb begin
    unique case (ctx)
      CTX_ALM: begin hour_o = bh[1]; min_o = bm[1]; sec_o = bs[1]; end
      CTX_TMR: begin hour_o = bh[2]; min_o = bm[2]; sec_o = bs[2]; end
      default: begin hour_o = bh[0]; min_o = bm[0]; sec_o = bs[0]; end
    endcase
  end

  assign disp_sel_o = ctx;

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctx == CTX_ADJ && field != SEL_SEC) |=> $stable(bs[0]));
  a_r4_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctx != CTX_ADJ && bs[0] != 8'h59) |=> (bs[0] != $past(bs[0])));
endmodule

// File: tb/tb_time_field_setter.sv
module tb_time_field_setter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       set_sw = 1'b1, ds_sw = 1'b1, key_n = 1'b1, inc_n = 1'b1, dec_n = 1'b1;
  logic [7:0] hour, min, sec;
  logic [1:0] dsel;
  int         n_tests = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  time_field_setter dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .set_sw_i(set_sw), .ds_sw_i(ds_sw), .key_ni(key_n),
    .inc_ni(inc_n), .dec_ni(dec_n),
    .hour_o(hour), .min_o(min), .sec_o(sec), .disp_sel_o(dsel)
  );

  // {set,ds,key_n,inc_n,dec_n} | sel | hh mm ss   (R1..R7, R11)
  localparam int NV = 35;
  localparam logic [30:0] VEC [NV] = '{
    {5'b11111, 2'b11, 8'h00, 8'h00, 8'h01},
    {5'b00111, 2'b00, 8'h00, 8'h00, 8'h02},
    {5'b00101, 2'b00, 8'h00, 8'h00, 8'h02},
    {5'b00011, 2'b00, 8'h00, 8'h00, 8'h02},
    {5'b00010, 2'b00, 8'h23, 8'h00, 8'h02},
    {5'b00101, 2'b00, 8'h00, 8'h00, 8'h02},
    {5'b00110, 2'b00, 8'h23, 8'h00, 8'h02},
    {5'b00011, 2'b00, 8'h23, 8'h00, 8'h02},
    {5'b00110, 2'b00, 8'h23, 8'h59, 8'h02},
    {5'b00101, 2'b00, 8'h23, 8'h00, 8'h02},
    {5'b00110, 2'b00, 8'h23, 8'h59, 8'h02},
    {5'b00011, 2'b00, 8'h23, 8'h59, 8'h02},
    {5'b00110, 2'b00, 8'h23, 8'h59, 8'h01},
    {5'b00110, 2'b00, 8'h23, 8'h59, 8'h00},
    {5'b00110, 2'b00, 8'h23, 8'h59, 8'h59},
    {5'b00100, 2'b00, 8'h23, 8'h59, 8'h00},
    {5'b00110, 2'b00, 8'h23, 8'h59, 8'h59},
    {5'b00011, 2'b00, 8'h23, 8'h59, 8'h59},
    {5'b00110, 2'b00, 8'h22, 8'h59, 8'h59},
    {5'b00101, 2'b00, 8'h23, 8'h59, 8'h59},
    {5'b11111, 2'b11, 8'h23, 8'h59, 8'h59},
    {5'b11111, 2'b11, 8'h00, 8'h00, 8'h00},
    {5'b01111, 2'b01, 8'h00, 8'h00, 8'h00},
    {5'b01101, 2'b01, 8'h00, 8'h00, 8'h00},
    {5'b01011, 2'b01, 8'h00, 8'h00, 8'h00},
    {5'b01101, 2'b01, 8'h01, 8'h00, 8'h00},
    {5'b10111, 2'b10, 8'h00, 8'h00, 8'h00},
    {5'b10101, 2'b10, 8'h00, 8'h00, 8'h00},
    {5'b10011, 2'b10, 8'h00, 8'h00, 8'h00},
    {5'b10110, 2'b10, 8'h23, 8'h00, 8'h00},
    {5'b10011, 2'b10, 8'h23, 8'h00, 8'h00},
    {5'b10101, 2'b10, 8'h23, 8'h01, 8'h00},
    {5'b01111, 2'b01, 8'h01, 8'h00, 8'h00},
    {5'b01101, 2'b01, 8'h01, 8'h00, 8'h00},
    {5'b11111, 2'b11, 8'h00, 8'h00, 8'h13}
  };

  task automatic check(input string tag, input logic [1:0] es,
                       input logic [7:0] eh, em, ec);
    n_tests++;
    if ({dsel, hour, min, sec} !== {es, eh, em, ec}) begin
      n_fail++;
      $display("FAIL %s: got sel=%b %h:%h:%h expected sel=%b %h:%h:%h",
               tag, dsel, hour, min, sec, es, eh, em, ec);
    end
  endtask

  // drive at negedge, tick spans one posedge, sample at next negedge
  task automatic do_tick(input logic [4:0] in);
    {set_sw, ds_sw, key_n, inc_n, dec_n} = in;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) do_tick(5'b11111);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(5ns * 190000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset state", 2'b11, 8'h00, 8'h00, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R11 vector walk
    for (int v = 0; v < NV; v++) begin
      do_tick(VEC[v][30:26]);
      check($sformatf("R1-vector row %0d (R2 R3 R5 R6 R7 R11)", v), VEC[v][25:24],
            VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R10: no tick, strobes active
    {key_n, inc_n, dec_n} = 3'b000;
    repeat (10) @(negedge clk);
    check("R10 hold without tick", 2'b11, 8'h00, 8'h00, 8'h13);
    {key_n, inc_n, dec_n} = 3'b111;

    // R8: reset clears alarm and timer too
    do_reset();
    check("R8 mid-run reset", 2'b11, 8'h00, 8'h00, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    do_tick(5'b01111);
    check("R8 alarm cleared", 2'b01, 8'h00, 8'h00, 8'h00);
    do_tick(5'b10111);
    check("R8 timer cleared", 2'b10, 8'h00, 8'h00, 8'h00);

    // R4 R9 carry chain of the running clock
    do_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_ticks(10);
    check("R9 units to tens", 2'b11, 8'h00, 8'h00, 8'h10);
    run_ticks(49);
    check("R4 before minute carry", 2'b11, 8'h00, 8'h00, 8'h59);
    run_ticks(1);
    check("R4 minute carry", 2'b11, 8'h00, 8'h01, 8'h00);
    run_ticks(3539);
    check("R4 before hour carry", 2'b11, 8'h00, 8'h59, 8'h59);
    run_ticks(1);
    check("R4 hour carry", 2'b11, 8'h01, 8'h00, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule